// File: doc/BRIEF.md
# Radio Event Timer

A 40-bit timebase for scheduling radio activity. The low part is a 16-bit base counter that counts up to a programmable period and then wraps. The high part is a 24-bit overflow counter that advances once for each completed base period. Software reaches every register through a byte-wide read/write port. Reading the low byte of the base counter freezes a copy of the remaining counter bytes, so a multi-byte read of the time is always coherent.

Four compare channels produce timed events. Two channels match the base counter and two match the overflow counter. Each channel has its own enable. A match produces a one-cycle pulse that the radio can use to start receive or transmit, and it sets a sticky flag that can raise the interrupt line. A 40-bit capture register stores the full time on a frame-sync event or on an end-of-packet event; a control bit picks which source is used. If a new capture arrives while the previous one is still unacknowledged, the new value overwrites it and a loss flag is raised.

Top module: `radio_event_timer`

## Requirements
- R1: After reset the base and overflow counters are 0, the period register reads 0xFF in both bytes, all flags read 0, the timer is stopped, and `cmp_pulse` and `irq` are low.
- R2: While the run bit (control register at address 22, bit 0) is 1, the base counter advances by one on each clock. While the run bit is 0, both counters hold their values.
- R3: When the base counter equals the period (addresses 5 and 6, low byte first), it holds that value for one cycle and then returns to 0. On that same edge the overflow counter increments by one.
- R4: A read of address 0 returns base bits 7:0 and, on that clock edge, latches base bits 15:8 and the overflow counter. Addresses 1 to 4 then return the latched bytes (base high, then overflow bytes low to high) however far the live counters have moved.
- R5: Base compare channel c (c = 0 or 1; registers at 7+2c, low byte first; enable at control bit 2+c) matches when the running base counter equals its value. `cmp_pulse[c]` is then high for exactly the next cycle, and flag bit c (address 23) becomes set.
- R6: Overflow compare channel c (c = 0 or 1; registers at 11+3c, low byte first; enable at control bit 4+c) fires when the overflow counter steps to its value. `cmp_pulse[2+c]` is high during the first cycle the new value is visible, and flag bit 2+c becomes set.
- R7: A channel whose enable bit is 0 produces no pulse and sets no flag, even when its compare value is reached.
- R8: On the selected capture event, {overflow, base} is stored in the capture register (addresses 17 to 21, low byte first), and flag bit 5 (capture valid) becomes set. Control bit 1 selects the source: 0 selects `frame_sync` and 1 selects `pkt_end`. The source that is not selected is ignored.
- R9: If a capture occurs while the valid flag is already set, the new value replaces the old one and flag bit 4 (capture lost) becomes set.
- R10: Writing 1 to a flag bit at address 23 clears that bit, and a new setting event in the same cycle takes priority over the clear. `irq` is high when any compare flag bit 3:0 is set and the matching bit of the mask register (address 24) is also 1.
- R11: Writing the control register with bit 6 set forces both counters to 0 on that edge. Bit 6 always reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_sync | input | 1 | One-cycle strobe when a frame delimiter is sent or received |
| pkt_end | input | 1 | One-cycle strobe when a packet ends |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used only for the counter snapshot) |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| cmp_pulse | output | 4 | One-cycle compare events: bits 1:0 base channels, bits 3:2 overflow channels |
| irq | output | 1 | Interrupt request from the masked compare flags |

## Verification
Every result has a fixed latency that the bench derives from the requirements. A write takes effect on the edge that ends its cycle. A counter value is visible on the negative edge after the edge that produced it. A compare pulse and its flag appear one cycle after the counter shows the matching base value, and in the same cycle the overflow counter first shows its matching value. A capture holds the counter values from the cycle in which the strobe was high. The driver counts negative edges from a clear of the counters so that it knows the exact counter value, and it queues each expectation for the cycle in which that expectation is due. The monitor compares the queued value at that instant, a quarter period away from the active edge.

// File: rtl/radio_event_timer.sv
module radio_event_timer #(
  parameter int BASE_W = 16,
  parameter int OVF_W  = 24,
  parameter int AW     = 5,
  parameter logic [BASE_W-1:0] PERIOD_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_sync,
  input  logic          pkt_end,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic [3:0]    cmp_pulse,
  output logic          irq
);
  localparam int NBB   = BASE_W / 8;
  localparam int NOB   = OVF_W / 8;
  localparam int NCB   = NBB + NOB;
  localparam int TW    = BASE_W + OVF_W;
  localparam int A_CNT = 0;
  localparam int A_PER = A_CNT + NCB;
  localparam int A_CB0 = A_PER + NBB;
  localparam int A_CO0 = A_CB0 + 2 * NBB;
  localparam int A_CAP = A_CO0 + 2 * NOB;
  localparam int A_CTL = A_CAP + NCB;
  localparam int A_FLG = A_CTL + 1;
  localparam int A_MSK = A_CTL + 2;

  logic [BASE_W-1:0] base_q, per_q;
  logic [OVF_W-1:0]  ovf_q;
  logic [BASE_W-1:0] cmpb_q [2];
  logic [OVF_W-1:0]  cmpo_q [2];
  logic [TW-1:0]     cap_q;
  logic [TW-9:0]     snap_q;
  logic              run_q, src_q, vld_q, lost_q;
  logic [3:0]        en_q, mask_q, sticky_q, evt_q, hit;

  wire              wr_ctl  = reg_wr && reg_addr == AW'(A_CTL);
  wire              wr_flg  = reg_wr && reg_addr == AW'(A_FLG);
  wire              clr     = wr_ctl && reg_wdata[6];
  wire              wrap    = run_q && base_q == per_q;
  wire [OVF_W-1:0]  ovf_nx  = ovf_q + OVF_W'(1);
  wire              trig    = src_q ? pkt_end : frame_sync;
  wire [3:0]        ack     = wr_flg ? reg_wdata[3:0] : 4'b0;

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      hit[c]   = en_q[c]   && run_q && base_q == cmpb_q[c];
      hit[c+2] = en_q[c+2] && wrap  && ovf_nx == cmpo_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      ovf_q    <= '0;
      per_q    <= PERIOD_RST;
      for (int c = 0; c < 2; c++) begin
        cmpb_q[c] <= '0;
        cmpo_q[c] <= '0;
      end
      cap_q    <= '0;
      snap_q   <= '0;
      run_q    <= 1'b0;
      src_q    <= 1'b0;
      vld_q    <= 1'b0;
      lost_q   <= 1'b0;
      en_q     <= '0;
      mask_q   <= '0;
      sticky_q <= '0;
      evt_q    <= '0;
    end else begin
      if (clr) begin
        base_q <= '0;
        ovf_q  <= '0;
      end else if (run_q) begin
        base_q <= wrap ? '0 : base_q + BASE_W'(1);
        if (wrap) ovf_q <= ovf_nx;
      end
      if (wr_ctl) begin
        run_q <= reg_wdata[0];
        src_q <= reg_wdata[1];
        en_q  <= reg_wdata[5:2];
      end
      if (reg_wr && reg_addr == AW'(A_MSK)) mask_q <= reg_wdata[3:0];
      for (int b = 0; b < NBB; b++)
        if (reg_wr && reg_addr == AW'(A_PER + b)) per_q[b*8 +: 8] <= reg_wdata;
      for (int c = 0; c < 2; c++) begin
        for (int b = 0; b < NBB; b++)
          if (reg_wr && reg_addr == AW'(A_CB0 + c * NBB + b)) cmpb_q[c][b*8 +: 8] <= reg_wdata;
        for (int b = 0; b < NOB; b++)
          if (reg_wr && reg_addr == AW'(A_CO0 + c * NOB + b)) cmpo_q[c][b*8 +: 8] <= reg_wdata;
      end
      if (reg_rd && reg_addr == AW'(A_CNT)) snap_q <= {ovf_q, base_q[BASE_W-1:8]};
      evt_q    <= hit;
      sticky_q <= (sticky_q & ~ack) | hit;
      if (trig) cap_q <= {ovf_q, base_q};
      vld_q  <= trig | (vld_q & ~(wr_flg & reg_wdata[5]));
      lost_q <= (trig & vld_q) | (lost_q & ~(wr_flg & reg_wdata[4]));
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(A_CNT)) reg_rdata = base_q[7:0];
    for (int k = 1; k < NCB; k++)
      if (reg_addr == AW'(A_CNT + k)) reg_rdata = snap_q[(k-1)*8 +: 8];
    for (int b = 0; b < NBB; b++) begin
      if (reg_addr == AW'(A_PER + b)) reg_rdata = per_q[b*8 +: 8];
      for (int c = 0; c < 2; c++)
        if (reg_addr == AW'(A_CB0 + c * NBB + b)) reg_rdata = cmpb_q[c][b*8 +: 8];
    end
    for (int b = 0; b < NOB; b++)
      for (int c = 0; c < 2; c++)
        if (reg_addr == AW'(A_CO0 + c * NOB + b)) reg_rdata = cmpo_q[c][b*8 +: 8];
    for (int k = 0; k < NCB; k++)
      if (reg_addr == AW'(A_CAP + k)) reg_rdata = cap_q[k*8 +: 8];
    if (reg_addr == AW'(A_CTL)) reg_rdata = {2'b00, en_q, src_q, run_q};
    if (reg_addr == AW'(A_FLG)) reg_rdata = {2'b00, vld_q, lost_q, sticky_q};
    if (reg_addr == AW'(A_MSK)) reg_rdata = {4'b0000, mask_q};
  end

  assign cmp_pulse = evt_q;
  assign irq       = |(sticky_q & mask_q);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !clr) |=> ($stable(base_q) && $stable(ovf_q)));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !clr) |=> (base_q == '0 && ovf_q == $past(ovf_q) + OVF_W'(1)));

  assert_pulse_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q != '0) |-> ((sticky_q & evt_q) == evt_q));

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q & ~$past(en_q)) == '0);

  assert_capture_lost_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && vld_q) |=> lost_q);
endmodule

// File: tb/tb_radio_event_timer.sv
module tb_radio_event_timer;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       frame_sync = 1'b0, pkt_end = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  wire  [7:0] reg_rdata;
  wire  [3:0] cmp_pulse;
  wire        irq;

  radio_event_timer dut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .pkt_end(pkt_end),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cmp_pulse(cmp_pulse), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;
  int         kq[$];
  logic [7:0] eq[$];
  string      tq[$];
  event       mon_ev;

  initial forever begin
    @(mon_ev);
    while (kq.size() > 0) begin
      int k;
      logic [7:0] e, act;
      string t;
      k = kq.pop_front();
      e = eq.pop_front();
      t = tq.pop_front();
      act = (k == 0) ? reg_rdata : (k == 1) ? {4'b0, cmp_pulse} : {7'b0, irq};
      n_chk++;
      if (act !== e) begin
        n_err++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", t, act, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic push(input int k, input logic [7:0] e, input string t);
    kq.push_back(k); eq.push_back(e); tq.push_back(t);
    -> mon_ev;
    #1;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] e, input string t);
    reg_addr = a; reg_rd = 1'b1;
    #1;
    push(0, e, t);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic sig(input int k, input logic [7:0] e, input string t);
    push(k, e, t);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    rd(5'd0,  8'h00, "R1 base after reset");
    rd(5'd23, 8'h00, "R1 flags after reset");
    rd(5'd5,  8'hFF, "R1 period reset low");
    rd(5'd6,  8'hFF, "R1 period reset high");
    sig(1, 8'h00, "R1 no pulse");
    sig(2, 8'h00, "R1 irq low");

    wr(5'd5, 8'd4); wr(5'd6, 8'd0);
    wr(5'd22, 8'h41);
    rd(5'd0, 8'd0, "R11 clear forces base 0");
    rd(5'd0, 8'd1, "R2 base counts");
    wr(5'd22, 8'h00);
    rd(5'd0, 8'd3, "R2 stop value");
    tick(3);
    rd(5'd0, 8'd3, "R2 holds while stopped");
    rd(5'd22, 8'h00, "R11 clear bit reads 0");

    wr(5'd22, 8'h01);
    rd(5'd0, 8'd3, "R3 before period");
    rd(5'd0, 8'd4, "R3 holds period value");
    rd(5'd0, 8'd0, "R3 wrapped to 0");
    rd(5'd2, 8'd1, "R3 overflow incremented");
    wr(5'd22, 8'h40);

    wr(5'd5, 8'd2);
    wr(5'd22, 8'h41);
    tick(10);
    rd(5'd0, 8'd1, "R4 low byte read");
    tick(6);
    rd(5'd2, 8'd3, "R4 coherent overflow byte");
    rd(5'd1, 8'd0, "R4 coherent base high");
    wr(5'd22, 8'h40);

    wr(5'd5, 8'd9);
    wr(5'd7, 8'd5); wr(5'd8, 8'd0);
    wr(5'd24, 8'h01);
    wr(5'd22, 8'h45);
    tick(5);
    sig(1, 8'h00, "R5 no pulse before match");
    tick(1);
    sig(1, 8'h01, "R5 base compare pulse");
    sig(2, 8'h01, "R10 masked flag raises irq");
    tick(1);
    sig(1, 8'h00, "R5 pulse lasts one cycle");
    rd(5'd23, 8'h01, "R5 sticky flag");
    wr(5'd23, 8'h01);
    sig(2, 8'h00, "R10 write-one clears flag");
    wr(5'd22, 8'h40);

    wr(5'd9, 8'd3); wr(5'd10, 8'd0);
    wr(5'd22, 8'h41);
    tick(15);
    rd(5'd23, 8'h00, "R7 disabled channels set no flag");
    sig(1, 8'h00, "R7 disabled channels no pulse");
    wr(5'd22, 8'h40);

    wr(5'd5, 8'd1);
    wr(5'd11, 8'd3); wr(5'd12, 8'd0); wr(5'd13, 8'd0);
    wr(5'd22, 8'h51);
    tick(5);
    sig(1, 8'h00, "R6 no pulse before step");
    tick(1);
    sig(1, 8'h04, "R6 overflow compare pulse");
    tick(1);
    sig(1, 8'h00, "R6 pulse lasts one cycle");
    sig(2, 8'h00, "R10 unmasked flag gives no irq");
    rd(5'd23, 8'h04, "R6 sticky flag");
    wr(5'd22, 8'h40);
    wr(5'd23, 8'h0F);

    wr(5'd5, 8'd9);
    wr(5'd22, 8'h41);
    tick(12);
    frame_sync = 1'b1;
    tick(1);
    frame_sync = 1'b0;
    wr(5'd22, 8'h00);
    rd(5'd17, 8'd2, "R8 capture base low");
    rd(5'd18, 8'd0, "R8 capture base high");
    rd(5'd19, 8'd1, "R8 capture overflow low");
    rd(5'd23, 8'h20, "R8 capture valid");
    pkt_end = 1'b1;
    tick(1);
    pkt_end = 1'b0;
    rd(5'd17, 8'd2, "R8 unselected source ignored");
    wr(5'd22, 8'h40);
    wr(5'd22, 8'h03);
    tick(3);
    pkt_end = 1'b1;
    tick(1);
    pkt_end = 1'b0;
    rd(5'd17, 8'd3, "R8 packet end source");
    rd(5'd23, 8'h30, "R9 capture lost flagged");
    wr(5'd23, 8'h30);
    rd(5'd23, 8'h00, "R10 capture flags cleared");

    tick(2);
    done = 1'b1;
    finish_run();
  end
endmodule